// File: doc/BRIEF.md
# Register Rename Mapping Table

This block keeps, for every architectural register, a record of whether a younger in-flight instruction has claimed it and which rename buffer will hold that instruction's result. A dispatch stage presents one instruction per cycle. Each of its source registers is looked up, and the answer is either "read the architectural file" or "read rename buffer N". If the instruction writes a register, that register's entry takes the rename buffer the allocator handed out, and the entry is marked as renamed.

When an instruction retires, its destination entry is released. This happens only if the entry still names the retiring buffer, because a younger rename of the same register must stay in place. A flush input discards every mapping at once, for example after a misprediction. Source lookup results are registered and appear one cycle after the dispatch that asked for them. The buffer storage and the issue logic sit outside this block.

Top module: `rename_map_table`

## Requirements
- R1: After reset no register is renamed, `lkp_valid` is 0, and every source lookup reports not renamed with buffer index 0.
- R2: A dispatch with `dsp_valid`=1 and `dsp_dst_en`=1 marks register `dsp_dst` as renamed to `dsp_buf`. Later lookups of that register return `lkp_renamed`=1 and that buffer index.
- R3: Renaming a register that is already renamed replaces its stored buffer index with the new one.
- R4: A lookup of a register that is not renamed returns `lkp_renamed`=0 and a buffer index of 0.
- R5: The lookup result for a dispatch is presented on the cycle after that dispatch with `lkp_valid`=1. `lkp_valid` is 0 after any cycle with no dispatch or with flush. Source k occupies bits [5k+4:5k] of `dsp_src` and is answered on `lkp_renamed[k]` and `lkp_buf[4k+3:4k]`.
- R6: The source lookups of a dispatching instruction see the mapping from before that instruction's own destination update, even when a source equals the destination.
- R7: A retirement (`ret_valid`=1) clears the entry of `ret_dst` only when that entry is renamed and its stored index equals `ret_buf`. Otherwise the entry is unchanged.
- R8: When a dispatch renames a register and a retirement targets the same register in the same cycle, the new mapping from the dispatch is kept.
- R9: `flush`=1 clears every entry. A dispatch or retirement presented in the same cycle has no effect, and no lookup result is produced for it.
- R10: A dispatch with `dsp_dst_en`=0 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all mappings |
| dsp_valid | input | 1 | An instruction is dispatched this cycle |
| dsp_dst_en | input | 1 | The dispatched instruction writes a register |
| dsp_dst | input | 5 | Destination architectural register |
| dsp_buf | input | 4 | Rename buffer allocated to the destination |
| dsp_src | input | 10 | Two source register numbers, source k in bits [5k+4:5k] |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_dst | input | 5 | Destination register of the retiring instruction |
| ret_buf | input | 4 | Rename buffer of the retiring instruction |
| lkp_valid | output | 1 | Lookup results below belong to the previous cycle's dispatch |
| lkp_renamed | output | 2 | Per source: 1 = read rename buffer, 0 = read architectural file |
| lkp_buf | output | 8 | Per source buffer index, source k in bits [4k+3:4k] |

## Verification
A reference table in the bench is driven with thousands of random dispatch and retire cycles. Destinations are drawn from a small register subset so that re-renames, stale retirements and matching retirements happen often, and each is told apart by the buffer index that later lookups return. Directed cycles cover the remaining cases. One has a source equal to its own destination, which distinguishes old from new mapping visibility. One retires a stale buffer next to a live one. One collides a dispatch and a retirement on the same register. One sends a dispatch without a destination write. One flushes while a dispatch is presented.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int RMT_ARCH_REGS = 32;
  localparam int RMT_BUF_BITS  = 4;
  localparam int RMT_SRC_PORTS = 2;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_SET   = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_e;
endpackage

// File: rtl/rmt_entry_store.sv
module rmt_entry_store #(
  parameter int NUM_ARCH = rmt_pkg::RMT_ARCH_REGS,
  parameter int BUF_W    = rmt_pkg::RMT_BUF_BITS,
  parameter int NUM_RD   = rmt_pkg::RMT_SRC_PORTS,
  localparam int AW      = $clog2(NUM_ARCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_dst,
  input  logic [BUF_W-1:0]        wr_buf,
  input  logic                    ret_en,
  input  logic [AW-1:0]           ret_dst,
  input  logic [BUF_W-1:0]        ret_buf,
  input  logic [NUM_RD*AW-1:0]    rd_addr,
  output logic [NUM_RD-1:0]       rd_hit,
  output logic [NUM_RD*BUF_W-1:0] rd_buf
);
  import rmt_pkg::*;

  logic [NUM_ARCH-1:0] valid_q;
  logic [BUF_W-1:0]    idx_q [NUM_ARCH];
  logic                ret_match;

  // Index array: single write port, no reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !flush) idx_q[wr_dst] <= wr_buf;
  end

  assign ret_match = ret_en && valid_q[ret_dst] && (idx_q[ret_dst] == ret_buf);

  for (genvar e = 0; e < NUM_ARCH; e++) begin : g_entry
    upd_e upd;
    logic v_q;
    always_comb begin
      if (wr_en && wr_dst == AW'(e))             upd = UPD_SET;
      else if (ret_match && ret_dst == AW'(e))   upd = UPD_CLEAR;
      else                                       upd = UPD_HOLD;
    end
    always_ff @(posedge clk) begin
      if (rst || flush) v_q <= 1'b0;
      else begin
        case (upd)
          UPD_SET:   v_q <= 1'b1;
          UPD_CLEAR: v_q <= 1'b0;
          default:   v_q <= v_q;
        endcase
      end
    end
    assign valid_q[e] = v_q;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [AW-1:0] a;
    assign a                      = rd_addr[p*AW +: AW];
    assign rd_hit[p]              = valid_q[a];
    assign rd_buf[p*BUF_W +: BUF_W] = valid_q[a] ? idx_q[a] : '0;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R9

  AST_DISPATCH_INSTALLS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> (valid_q[$past(wr_dst)] && idx_q[$past(wr_dst)] == $past(wr_buf))); // R2

  AST_STALE_RETIRE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !flush && !(wr_en && wr_dst == ret_dst) && valid_q[ret_dst] && idx_q[ret_dst] != ret_buf)
    |=> valid_q[$past(ret_dst)]); // R7
endmodule

// File: rtl/rmt_src_port.sv
module rmt_src_port #(
  parameter int BUF_W = rmt_pkg::RMT_BUF_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             hit,
  input  logic [BUF_W-1:0] buf_in,
  output logic             renamed_q,
  output logic [BUF_W-1:0] buf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      renamed_q <= 1'b0;
      buf_q     <= '0;
    end else if (load) begin
      renamed_q <= hit;
      buf_q     <= hit ? buf_in : '0;
    end
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = rmt_pkg::RMT_ARCH_REGS,
  parameter int BUF_W    = rmt_pkg::RMT_BUF_BITS,
  parameter int NUM_SRC  = rmt_pkg::RMT_SRC_PORTS,
  localparam int AW      = $clog2(NUM_ARCH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     dsp_valid,
  input  logic                     dsp_dst_en,
  input  logic [AW-1:0]            dsp_dst,
  input  logic [BUF_W-1:0]         dsp_buf,
  input  logic [NUM_SRC*AW-1:0]    dsp_src,
  input  logic                     ret_valid,
  input  logic [AW-1:0]            ret_dst,
  input  logic [BUF_W-1:0]         ret_buf,
  output logic                     lkp_valid,
  output logic [NUM_SRC-1:0]       lkp_renamed,
  output logic [NUM_SRC*BUF_W-1:0] lkp_buf
);
  logic                     fire;
  logic                     wr_en;
  logic [NUM_SRC-1:0]       hit;
  logic [NUM_SRC*BUF_W-1:0] hit_buf;

  assign fire  = dsp_valid && !flush;
  assign wr_en = dsp_valid && dsp_dst_en;

  rmt_entry_store #(.NUM_ARCH(NUM_ARCH), .BUF_W(BUF_W), .NUM_RD(NUM_SRC)) i_store (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_dst  (dsp_dst),
    .wr_buf  (dsp_buf),
    .ret_en  (ret_valid),
    .ret_dst (ret_dst),
    .ret_buf (ret_buf),
    .rd_addr (dsp_src),
    .rd_hit  (hit),
    .rd_buf  (hit_buf)
  );

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
    rmt_src_port #(.BUF_W(BUF_W)) i_port (
      .clk       (clk),
      .rst       (rst),
      .load      (fire),
      .hit       (hit[p]),
      .buf_in    (hit_buf[p*BUF_W +: BUF_W]),
      .renamed_q (lkp_renamed[p]),
      .buf_q     (lkp_buf[p*BUF_W +: BUF_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lkp_valid <= 1'b0;
    else     lkp_valid <= fire;
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !flush) |=> lkp_valid); // R5

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!dsp_valid || flush) |=> !lkp_valid); // R9

  AST_ARCH_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && !lkp_renamed[0]) |-> (lkp_buf[BUF_W-1:0] == '0)); // R4
endmodule

// File: tb/test_rename_map_table.sv
module test_rename_map_table;
  localparam int NA = 32;
  localparam int AW = 5;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic dsp_valid = 1'b0, dsp_dst_en = 1'b0;
  logic [AW-1:0] dsp_dst = '0;
  logic [BW-1:0] dsp_buf = '0;
  logic [2*AW-1:0] dsp_src = '0;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_dst = '0;
  logic [BW-1:0] ret_buf = '0;
  logic lkp_valid;
  logic [1:0] lkp_renamed;
  logic [2*BW-1:0] lkp_buf;

  always #2 clk = ~clk;

  rename_map_table i_rename_map_table (
    .clk(clk), .rst(rst), .flush(flush),
    .dsp_valid(dsp_valid), .dsp_dst_en(dsp_dst_en), .dsp_dst(dsp_dst),
    .dsp_buf(dsp_buf), .dsp_src(dsp_src),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_buf(ret_buf),
    .lkp_valid(lkp_valid), .lkp_renamed(lkp_renamed), .lkp_buf(lkp_buf)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_v [NA];
  logic [BW-1:0] m_b [NA];
  bit          e_ov;
  bit          e_ren [2];
  logic [BW-1:0] e_buf [2];

  function automatic bit ref_ren(input logic [AW-1:0] r);
    return m_v[r];
  endfunction

  function automatic logic [BW-1:0] ref_buf(input logic [AW-1:0] r);
    return m_v[r] ? m_b[r] : '0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the negedge, update the reference model, then check the registered result.
  task automatic cyc(input bit dv, input bit de, input int d, input int bf,
                     input int s0, input int s1, input bit rv, input int rd,
                     input int rb, input bit fl, input string tag);
    dsp_valid = dv; dsp_dst_en = de; dsp_dst = AW'(d); dsp_buf = BW'(bf);
    dsp_src = {AW'(s1), AW'(s0)};
    ret_valid = rv; ret_dst = AW'(rd); ret_buf = BW'(rb); flush = fl;
    e_ov = dv && !fl;
    if (e_ov) begin
      e_ren[0] = ref_ren(AW'(s0)); e_buf[0] = ref_buf(AW'(s0));
      e_ren[1] = ref_ren(AW'(s1)); e_buf[1] = ref_buf(AW'(s1));
    end
    if (fl) begin
      for (int i = 0; i < NA; i++) m_v[i] = 0;
    end else begin
      if (rv && m_v[rd] && m_b[rd] == BW'(rb)) m_v[rd] = 0;
      if (dv && de) begin m_v[d] = 1; m_b[d] = BW'(bf); end
    end
    @(posedge clk);
    @(negedge clk);
    dsp_valid = 0; ret_valid = 0; flush = 0;
    chk(tag, "lkp_valid", int'(lkp_valid), int'(e_ov));
    if (e_ov) begin
      for (int k = 0; k < 2; k++) begin
        chk(tag, "lkp_renamed", int'(lkp_renamed[k]), int'(e_ren[k]));
        chk(tag, "lkp_buf", int'(lkp_buf[k*BW +: BW]), int'(e_buf[k]));
      end
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    for (int i = 0; i < NA; i++) begin m_v[i] = 0; m_b[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1", "lkp_valid after reset", int'(lkp_valid), 0);
    // R1: every register reads as not renamed
    for (int r = 0; r < NA; r += 2) cyc(1, 0, 0, 0, r, r + 1, 0, 0, 0, 0, "R1");
    // R6: source equal to own destination sees old mapping
    cyc(1, 1, 5, 9, 5, 5, 0, 0, 0, 0, "R6");
    // R2 / R5: next dispatch sees the new mapping
    cyc(1, 0, 0, 0, 5, 6, 0, 0, 0, 0, "R2");
    // R3: rename again replaces the index
    cyc(1, 1, 5, 3, 5, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 5, 5, 0, 0, 0, 0, "R3");
    // R7: stale retire leaves the entry alone, matching retire clears it
    cyc(0, 0, 0, 0, 0, 0, 1, 5, 9, 0, "R5");
    cyc(1, 0, 0, 0, 5, 1, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 5, 3, 0, "R5");
    cyc(1, 0, 0, 0, 5, 5, 0, 0, 0, 0, "R4");
    // R8: dispatch and retire on the same register in one cycle
    cyc(1, 1, 7, 2, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 1, 7, 4, 7, 7, 1, 7, 2, 0, "R8");
    cyc(1, 0, 0, 0, 7, 8, 0, 0, 0, 0, "R8");
    // R10: no destination write leaves the table unchanged
    cyc(1, 0, 8, 11, 8, 7, 0, 0, 0, 0, "R10");
    cyc(1, 0, 0, 0, 8, 8, 0, 0, 0, 0, "R10");
    // R9: flush with a dispatch in the same cycle
    cyc(1, 1, 9, 6, 7, 9, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 0, 7, 9, 0, 0, 0, 0, "R9");
    // Random phase over a small register subset
    for (int n = 0; n < 4000; n++) begin
      int d, rd, rb;
      bit rv;
      d  = $urandom_range(0, 7);
      rd = $urandom_range(0, 7);
      rv = ($urandom_range(0, 2) == 0);
      rb = ($urandom_range(0, 1) == 0) ? int'(m_b[rd]) : $urandom_range(0, 15);
      cyc(($urandom_range(0, 4) != 0), ($urandom_range(0, 3) != 0), d,
          $urandom_range(0, 15), $urandom_range(0, 9), $urandom_range(0, 9),
          rv, rd, rb, ($urandom_range(0, 199) == 0), "R2");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule